// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable, clock-sampled model of a 16-bit static memory with active-low controls. The controls are chip select, output enable, write enable and one enable for each byte lane. It turns each combination of these pins into one of the following: deselected, outputs disabled, lower-byte, upper-byte or word read, or lower-byte, upper-byte or word write. For each 8-bit lane it drives data only where the combination calls for it. The tri-state bus is split into a data-out vector and one drive flag per lane, so the surrounding logic or a bench resolves the bus itself.

A write is the overlap of chip select low and write enable low. A fast clock samples the pins. While the overlap is seen, the address, write data and byte enables are held in a staging register. On the first edge at which the overlap is gone, the staged lanes are committed to the array. Storage depth is a power-of-two parameter. Address bits above the implemented depth do not take part in decoding, so those addresses alias.

Top module: `bytelane_sram`

## Requirements
- R1: With `cs_n` high, `lane_drive` is 2'b00 and no stored word changes, whatever the levels on `we_n`, `oe_n`, `lb_n` and `ub_n`.
- R2: With `cs_n` low and both `oe_n` and `we_n` high, `lane_drive` is 2'b00.
- R3: With `cs_n` low and both `lb_n` and `ub_n` high, `lane_drive` is 2'b00 and a write overlap changes no stored word.
- R4: With `cs_n` low, `oe_n` low and `we_n` high, `lane_drive[0]` is set exactly when `lb_n` is low and `lane_drive[1]` exactly when `ub_n` is low. A driven lane carries the stored bits of the addressed word: lane 0 on bits 7:0 and lane 1 on bits 15:8.
- R5: While `cs_n` and `we_n` are both low, `lane_drive` is 2'b00 whatever the level of `oe_n`.
- R6: A write ends at the first clock edge where `cs_n` or `we_n` is seen high, whichever rises first. The word committed uses the address, data and byte enables sampled on the last edge of the overlap. The new value is readable from the cycle after that ending edge.
- R7: In a write, a lane whose byte enable is high keeps its previous contents.
- R8: Only the low `DEPTH_LOG2` address bits select a word. Addresses that differ only above them reach the same word.
- R9: Asserting `rst_n` low discards a write overlap that has not yet ended, so that overlap stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than any control pulse |
| rst_n | input | 1 | Active-low asynchronous reset of the write staging |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| lb_n | input | 1 | Active-low enable for bits 7:0 |
| ub_n | input | 1 | Active-low enable for bits 15:8 |
| addr | input | ADDR_W (17) | Word address |
| data_in | input | 2*LANE_W (16) | Write data from the bus |
| data_out | output | 2*LANE_W (16) | Read data, meaningful on driven lanes |
| lane_drive | output | 2 | Per-lane drive flag; bit 0 for bits 7:0, bit 1 for bits 15:8 |

## Verification
Assertions check the drive rules on every cycle: no lane is driven when the chip is deselected, when outputs are disabled, when neither byte is enabled, or while a write overlap is active. They also check that a pending write commits in exactly one cycle and that its staged address does not move after the overlap ends. Whether the right word and lanes were stored, whether masked lanes survive, whether addresses alias, and whether reset drops an open write can only be seen through the bench's write-then-read scenarios.

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
  parameter int ADDR_W     = 17,
  parameter int DEPTH_LOG2 = 6,
  parameter int LANE_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  oe_n,
  input  logic                  we_n,
  input  logic                  lb_n,
  input  logic                  ub_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANE_W-1:0]   data_in,
  output logic [2*LANE_W-1:0]   data_out,
  output logic [1:0]            lane_drive
);
  localparam int DATA_W = 2 * LANE_W;
  localparam int DEPTH  = 1 << DEPTH_LOG2;

  logic [DEPTH_LOG2-1:0] idx;
  logic [1:0]            be;
  logic                  wr_act;
  logic                  rd_act;
  logic                  commit;

  logic                  wr_pend;
  logic [DEPTH_LOG2-1:0] w_idx;
  logic [DATA_W-1:0]     w_data;
  logic [1:0]            w_be;

  assign idx    = addr[DEPTH_LOG2-1:0];
  assign be     = ~{ub_n, lb_n};
  assign wr_act = ~cs_n & ~we_n;
  assign rd_act = ~cs_n & ~oe_n & we_n;
  assign commit = wr_pend & ~wr_act;

  assign lane_drive = rd_act ? be : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend <= 1'b0;
      w_idx   <= '0;
      w_data  <= '0;
      w_be    <= 2'b00;
    end else if (wr_act) begin
      wr_pend <= 1'b1;
      w_idx   <= idx;
      w_data  <= data_in;
      w_be    <= be;
    end else begin
      wr_pend <= 1'b0;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && w_be[g])
        mem[w_idx] <= w_data[g*LANE_W +: LANE_W];
    end

    assign data_out[g*LANE_W +: LANE_W] = mem[idx];
  end

  p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> lane_drive == 2'b00);

  p_outdis_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && oe_n && we_n) |-> lane_drive == 2'b00);

  p_nobyte_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n && ub_n) |-> lane_drive == 2'b00);

  p_nodrive_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |-> lane_drive == 2'b00);

  p_commit_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && (cs_n || we_n)) |=> !wr_pend);

  p_stage_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && (cs_n || we_n)) |=> $stable(w_idx) && $stable(w_data));
endmodule

// File: tb/bytelane_sram_tb_top.sv
module bytelane_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [16:0] addr = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic [1:0]  lane_drive;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bytelane_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .lane_drive(lane_drive));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
  endtask

  task automatic wr(input logic [16:0] a, input logic [15:0] d,
                    input logic lbn, input logic ubn, input logic oen, input bit by_cs);
    @(negedge clk);
    addr = a; data_in = d; lb_n = lbn; ub_n = ubn; oe_n = oen;
    cs_n = 1'b0; we_n = 1'b0;
    #1 chk("R5 drive during write", {14'd0, lane_drive}, 16'd0);
    @(negedge clk);
    if (by_cs) cs_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input string tag, input logic [16:0] a, input logic lbn,
                    input logic ubn, input logic [1:0] exp_drv, input logic [15:0] exp_d);
    @(negedge clk);
    addr = a; lb_n = lbn; ub_n = ubn; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1;
    chk({tag, " drive"}, {14'd0, lane_drive}, {14'd0, exp_drv});
    if (exp_drv[0]) chk({tag, " low lane"}, {8'd0, data_out[7:0]}, {8'd0, exp_d[7:0]});
    if (exp_drv[1]) chk({tag, " high lane"}, {8'd0, data_out[15:8]}, {8'd0, exp_d[15:8]});
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    #1 chk("R1 idle after reset", {14'd0, lane_drive}, 16'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_word_and_bytes();
    wr(17'h3, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b0);
    rd("R4 word read", 17'h3, 1'b0, 1'b0, 2'b11, 16'h1234);
    rd("R4 low byte read", 17'h3, 1'b0, 1'b1, 2'b01, 16'h1234);
    rd("R4 high byte read", 17'h3, 1'b1, 1'b0, 2'b10, 16'h1234);
    wr(17'h4, 16'hABCD, 1'b0, 1'b0, 1'b1, 1'b1);
    rd("R6 cs-ended write", 17'h4, 1'b0, 1'b0, 2'b11, 16'hABCD);
  endtask

  task automatic t_masked();
    wr(17'h3, 16'h55EE, 1'b0, 1'b1, 1'b0, 1'b0);
    rd("R7 upper kept", 17'h3, 1'b0, 1'b0, 2'b11, 16'h12EE);
    wr(17'h3, 16'h99AA, 1'b1, 1'b0, 1'b1, 1'b1);
    rd("R7 lower kept", 17'h3, 1'b0, 1'b0, 2'b11, 16'h99EE);
    wr(17'h4, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0);
    rd("R3 no-byte write", 17'h4, 1'b0, 1'b0, 2'b11, 16'hABCD);
    rd("R3 no-byte read", 17'h4, 1'b1, 1'b1, 2'b00, 16'h0000);
  endtask

  task automatic t_desel_and_disabled();
    @(negedge clk);
    addr = 17'h4; data_in = 16'h0000; lb_n = 1'b0; ub_n = 1'b0; oe_n = 1'b0;
    cs_n = 1'b1; we_n = 1'b0;
    #1 chk("R1 deselected drive", {14'd0, lane_drive}, 16'd0);
    repeat (2) @(negedge clk);
    idle();
    rd("R1 no write when deselected", 17'h4, 1'b0, 1'b0, 2'b11, 16'hABCD);
    @(negedge clk);
    addr = 17'h4; lb_n = 1'b0; ub_n = 1'b0; cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    #1 chk("R2 outputs disabled", {14'd0, lane_drive}, 16'd0);
    @(negedge clk);
    idle();
  endtask

  task automatic t_last_edge();
    @(negedge clk);
    addr = 17'h9; data_in = 16'h1111; lb_n = 1'b0; ub_n = 1'b0; cs_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    data_in = 16'h2222;
    @(negedge clk);
    data_in = 16'h3333; we_n = 1'b1;
    @(posedge clk);
    #1 addr = 17'h9; cs_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    #1 chk("R6 last sampled data, next-cycle read", data_out, 16'h2222);
    idle();
  endtask

  task automatic t_alias();
    wr(17'h10007, 16'hC0DE, 1'b0, 1'b0, 1'b1, 1'b0);
    rd("R8 alias low address", 17'h00007, 1'b0, 1'b0, 2'b11, 16'hC0DE);
    wr(17'h00047, 16'hBEEF, 1'b0, 1'b0, 1'b1, 1'b0);
    rd("R8 alias other high bits", 17'h1FFC7, 1'b0, 1'b0, 2'b11, 16'hBEEF);
  endtask

  task automatic t_reset_midwrite();
    wr(17'h5, 16'h0F0F, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    addr = 17'h5; data_in = 16'h7777; lb_n = 1'b0; ub_n = 1'b0; cs_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    rd("R9 open write dropped by reset", 17'h5, 1'b0, 1'b0, 2'b11, 16'h0F0F);
  endtask

  initial begin
    t_reset();
    t_word_and_bytes();
    t_masked();
    t_desel_and_disabled();
    t_last_edge();
    t_alias();
    t_reset_midwrite();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule